// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner

The aligner sits behind a serial receiver. Each bit arrives on `ser_i`, and `bit_en_i` marks the cycle in which that bit is valid. Clock recovery happens upstream. The line carries 18-bit frames. Each frame opens with a clock bit at 1 and closes with a clock bit at 0, and 16 payload bits sit between the two. The frame boundary is therefore always a 0-to-1 step.

The aligner keeps a sliding window of the last 18 bits. A free-running counter tags each bit position with its offset inside the frame. For every offset, the aligner counts how many frames in a row showed correct clock bits. It declares lock when one offset collects enough good frames.

From then on it delivers one 16-bit word per good frame. The active-low lock output falls in the same cycle as the first word. A loss-of-signal flag clears together with it. Repeated framing errors drop lock and restart the search.

A power-down input holds the whole block idle. An output-enable input gates the parallel word for a shared bus.

Top module: `ecd_frame_aligner`

## Requirements
- R1: A good frame is 18 consecutive bits in arrival order: a 1, then payload bits 0 to 15 with the least significant bit first, then a 0. `data_o` presents the payload with bit 0 taken from the second bit received.
- R2: The search covers all 18 offsets. Lock is declared at the end of the 4th consecutive good frame at one offset, and no earlier.
- R3: `valid_o` is high for exactly one cycle per good frame, only while locked, and only at the last bit of that frame. It is never high in the middle of a frame.
- R4: `lock_no_o` and `los_o` are both 1 from reset and whenever the block is unlocked. Both go to 0 on lock, and both return to 1 on loss of lock.
- R5: `lock_no_o` falls in the same cycle that `valid_o` presents the first word.
- R6: While locked, one frame with a wrong start or stop bit produces no word and keeps lock. A good frame after it clears the error count.
- R7: While locked, 2 consecutive bad frames drop lock at the end of the second one. The search then restarts, and lock can be regained at a different offset.
- R8: A cycle with `bit_en_i` low changes nothing and emits no word. Idle cycles placed anywhere inside frames do not alter the recovered words.
- R9: While `pwrdn_i` is high, the block discards input, holds `lock_no_o`=1, `los_o`=1 and `valid_o`=0, and clears its search state.
- R10: `data_oe_o` equals `oe_i` while powered up and is 0 in power-down. `data_o` reads 0 whenever `data_oe_o` is 0.
- R11: A sync stream with payload 16'h00FF (nine 1s followed by nine 0s) qualifies at exactly one offset. After any leading junk, the first word after lock is 16'h00FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Received bit valid this cycle |
| ser_i | input | 1 | Received serial bit |
| pwrdn_i | input | 1 | Power-down, holds block idle |
| oe_i | input | 1 | Parallel output enable request |
| data_o | output | 16 | Recovered payload word |
| valid_o | output | 1 | One-cycle strobe for a new word |
| data_oe_o | output | 1 | Drive enable for the parallel word |
| lock_no_o | output | 1 | Frame lock, active low |
| los_o | output | 1 | Local loss-of-signal flag |

## Verification
The properties assume that `bit_en_i` and `ser_i` only change between clock edges. They also assume `pwrdn_i` is held for whole cycles. Beyond that, any bit pattern is legal, including framing errors.

The bench drives every input at the falling edge. It only injects idle cycles between bits. To acquire lock, it always uses the sync payload, so random payloads cannot create a false competing offset. Random payloads start only once lock is held, when offset search is disabled.

// File: rtl/ecd_align_pkg.sv
package ecd_align_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } align_state_e;
endpackage

// File: rtl/ecd_frame_shift.sv
module ecd_frame_shift #(
  parameter int unsigned FRAME_W = 18,
  localparam int unsigned PW = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               shift_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] win_nxt_o,
  output logic [PW-1:0]      phase_o
);
  logic [FRAME_W-1:0] win_q;
  logic [PW-1:0]      phase_q;

  // newest bit enters at the top; bit 0 is the oldest
  assign win_nxt_o = {bit_i, win_q[FRAME_W-1:1]};
  assign phase_o   = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      phase_q <= '0;
    end else if (clr_i) begin
      win_q   <= '0;
      phase_q <= '0;
    end else if (shift_i) begin
      win_q   <= win_nxt_o;
      phase_q <= (phase_q == PW'(FRAME_W-1)) ? '0 : phase_q + PW'(1);
    end
  end
endmodule

// File: rtl/ecd_offset_score.sv
module ecd_offset_score #(
  parameter int unsigned FRAME_W     = 18,
  parameter int unsigned LOCK_FRAMES = 4,
  localparam int unsigned PW = $clog2(FRAME_W),
  localparam int unsigned CW = $clog2(LOCK_FRAMES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [PW-1:0] phase_i,
  input  logic          good_i,
  output logic          hit_o
);
  logic [FRAME_W-1:0] ripe_vec;

  for (genvar g = 0; g < FRAME_W; g++) begin : g_off
    logic [CW-1:0] cnt_q;
    logic          sel;
    assign sel         = (phase_i == PW'(g));
    assign ripe_vec[g] = sel && (cnt_q == CW'(LOCK_FRAMES - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else if (clr_i) begin
        cnt_q <= '0;
      end else if (en_i && sel) begin
        if (!good_i)
          cnt_q <= '0;
        else if (cnt_q != CW'(LOCK_FRAMES - 1))
          cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // this frame is the LOCK_FRAMES-th good one at the current offset
  assign hit_o = en_i && good_i && (|ripe_vec);
endmodule

// File: rtl/ecd_lock_ctrl.sv
module ecd_lock_ctrl
  import ecd_align_pkg::*;
#(
  parameter int unsigned FRAME_W     = 18,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned LOSS_FRAMES = 2,
  localparam int unsigned PW = $clog2(FRAME_W),
  localparam int unsigned LW = $clog2(LOSS_FRAMES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwrdn_i,
  input  logic              bit_en_i,
  input  logic [PW-1:0]     phase_i,
  input  logic              good_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              locked_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              lock_no_o,
  output logic              los_o
);
  align_state_e      state_q;
  logic [PW-1:0]     lock_phase_q;
  logic [LW-1:0]     bad_q;
  logic              valid_q, lock_n_q, los_q;
  logic [DATA_W-1:0] data_q;
  logic              frame_end;

  assign frame_end = bit_en_i && (phase_i == lock_phase_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_SEARCH;
      lock_phase_q <= '0;
      bad_q        <= '0;
      valid_q      <= 1'b0;
      data_q       <= '0;
      lock_n_q     <= 1'b1;
      los_q        <= 1'b1;
    end else if (pwrdn_i) begin
      state_q      <= ST_SEARCH;
      lock_phase_q <= '0;
      bad_q        <= '0;
      valid_q      <= 1'b0;
      lock_n_q     <= 1'b1;
      los_q        <= 1'b1;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_SEARCH: begin
          if (hit_i) begin
            state_q      <= ST_LOCKED;
            lock_phase_q <= phase_i;
            bad_q        <= '0;
            valid_q      <= 1'b1;
            data_q       <= word_i;
            lock_n_q     <= 1'b0;
            los_q        <= 1'b0;
          end
        end
        ST_LOCKED: begin
          if (frame_end) begin
            if (good_i) begin
              valid_q <= 1'b1;
              data_q  <= word_i;
              bad_q   <= '0;
            end else if (bad_q == LW'(LOSS_FRAMES - 1)) begin
              state_q  <= ST_SEARCH;
              bad_q    <= '0;
              lock_n_q <= 1'b1;
              los_q    <= 1'b1;
            end else begin
              bad_q <= bad_q + LW'(1);
            end
          end
        end
        default: state_q <= ST_SEARCH;
      endcase
    end
  end

  assign locked_o  = (state_q == ST_LOCKED);
  assign valid_o   = valid_q;
  assign data_o    = data_q;
  assign lock_no_o = lock_n_q;
  assign los_o     = los_q;
endmodule

// File: rtl/ecd_frame_aligner.sv
module ecd_frame_aligner #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned LOCK_FRAMES = 4,
  parameter int unsigned LOSS_FRAMES = 2,
  localparam int unsigned FRAME_W = DATA_W + 2,
  localparam int unsigned PW      = $clog2(FRAME_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              ser_i,
  input  logic              pwrdn_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              data_oe_o,
  output logic              lock_no_o,
  output logic              los_o
);
  logic [FRAME_W-1:0] win_nxt;
  logic [PW-1:0]      phase;
  logic               good, hit, locked;
  logic [DATA_W-1:0]  word_q;

  ecd_frame_shift #(.FRAME_W(FRAME_W)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (pwrdn_i),
    .shift_i   (bit_en_i && !pwrdn_i),
    .bit_i     (ser_i),
    .win_nxt_o (win_nxt),
    .phase_o   (phase)
  );

  // start clock bit is the oldest, stop clock bit the newest
  assign good = win_nxt[0] && !win_nxt[FRAME_W-1];

  ecd_offset_score #(.FRAME_W(FRAME_W), .LOCK_FRAMES(LOCK_FRAMES)) i_score (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (pwrdn_i || locked),
    .en_i    (bit_en_i && !pwrdn_i && !locked),
    .phase_i (phase),
    .good_i  (good),
    .hit_o   (hit)
  );

  ecd_lock_ctrl #(
    .FRAME_W(FRAME_W), .DATA_W(DATA_W), .LOSS_FRAMES(LOSS_FRAMES)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwrdn_i   (pwrdn_i),
    .bit_en_i  (bit_en_i),
    .phase_i   (phase),
    .good_i    (good),
    .hit_i     (hit),
    .word_i    (win_nxt[FRAME_W-2:1]),
    .locked_o  (locked),
    .valid_o   (valid_o),
    .data_o    (word_q),
    .lock_no_o (lock_no_o),
    .los_o     (los_o)
  );

  assign data_oe_o = oe_i && !pwrdn_i;
  assign data_o    = data_oe_o ? word_q : '0;
endmodule

// File: rtl/ecd_align_chk.sv
module ecd_align_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic pwrdn_i,
  input logic valid_o,
  input logic lock_no_o,
  input logic los_o
);
  p_word_needs_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !lock_no_o);
  p_lock_with_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_no_o) |-> valid_o);
  p_lock_on_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_no_o) |-> $past(bit_en_i));
  p_loss_sets_los_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_no_o) |-> los_o);
  p_idle_no_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> !valid_o);
  p_pwrdn_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_i |=> (lock_no_o && los_o && !valid_o));
endmodule

bind ecd_frame_aligner ecd_align_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_en_i  (bit_en_i),
  .pwrdn_i   (pwrdn_i),
  .valid_o   (valid_o),
  .lock_no_o (lock_no_o),
  .los_o     (los_o)
);

// File: tb/test_ecd_frame_aligner.sv
`timescale 1ns/1ps
module test_ecd_frame_aligner;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_en_i = 1'b0;
  logic        ser_i = 1'b0;
  logic        pwrdn_i = 1'b0;
  logic        oe_i = 1'b1;
  logic [15:0] data_o;
  logic        valid_o, data_oe_o, lock_no_o, los_o;

  int errors = 0;
  int checks = 0;
  bit mid_word = 0;
  bit use_gaps = 0;
  logic        f_v, f_lk;
  logic [15:0] f_d;

  localparam logic [15:0] SYNC = 16'h00FF;

  always #2.5 clk_i = ~clk_i;

  ecd_frame_aligner i_ecd_frame_aligner (
    .clk_i, .rst_ni, .bit_en_i, .ser_i, .pwrdn_i, .oe_i,
    .data_o, .valid_o, .data_oe_o, .lock_no_o, .los_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    if (use_gaps && ($urandom % 4 == 0)) begin
      @(negedge clk_i);
      bit_en_i = 1'b0;
      ser_i    = ~b;
    end
    @(negedge clk_i);
    ser_i    = b;
    bit_en_i = 1'b1;
    @(posedge clk_i);
    #1;
    bit_en_i = 1'b0;
  endtask

  task automatic send_frame(input logic [15:0] d, input logic st, input logic sp);
    put_bit(st);
    if (valid_o) mid_word = 1;
    for (int i = 0; i < 16; i++) begin
      put_bit(d[i]);
      if (valid_o) mid_word = 1;
    end
    put_bit(sp);
    f_v  = valid_o;
    f_d  = data_o;
    f_lk = lock_no_o;
  endtask

  task automatic acquire(input string req);
    for (int k = 0; k < 3; k++) begin
      send_frame(SYNC, 1'b1, 1'b0);
      check({req, " no lock before 4 frames R2"}, {31'd0, f_lk}, 32'd1);
    end
    send_frame(SYNC, 1'b1, 1'b0);
    check({req, " lock on 4th frame R2"}, {31'd0, f_lk}, 32'd0);
    check({req, " word with lock R5"}, {31'd0, f_v}, 32'd1);
    check({req, " sync word R11"}, {16'd0, f_d}, {16'd0, SYNC});
    check({req, " los cleared R4"}, {31'd0, los_o}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("reset lock_no R4", {31'd0, lock_no_o}, 32'd1);
    check("reset los R4", {31'd0, los_o}, 32'd1);
    check("reset valid R3", {31'd0, valid_o}, 32'd0);
    check("reset oe R10", {31'd0, data_oe_o}, 32'd1);

    acquire("first");

    // random payloads with idle gaps, checked word by word
    use_gaps = 1;
    for (int n = 0; n < 24; n++) begin
      d = 16'($urandom);
      send_frame(d, 1'b1, 1'b0);
      check("random word valid R1", {31'd0, f_v}, 32'd1);
      check("random word data R1 R8", {16'd0, f_d}, {16'd0, d});
      check("lock held R4", {31'd0, f_lk}, 32'd0);
    end
    use_gaps = 0;
    check("no mid-frame word R3", {31'd0, mid_word}, 32'd0);

    // isolated errors keep lock
    send_frame(16'h1234, 1'b0, 1'b0);
    check("bad start no word R6", {31'd0, f_v}, 32'd0);
    check("bad start keeps lock R6", {31'd0, f_lk}, 32'd0);
    send_frame(16'hA5C3, 1'b1, 1'b0);
    check("good after bad R6", {16'd0, f_d}, 32'h0000A5C3);
    send_frame(16'h0F0F, 1'b1, 1'b1);
    check("bad stop keeps lock R6", {31'd0, f_lk}, 32'd0);
    send_frame(16'hBEEF, 1'b1, 1'b0);
    check("count cleared R6", {31'd0, f_v}, 32'd1);
    check("count cleared data R6", {16'd0, f_d}, 32'h0000BEEF);

    // two bad frames in a row
    send_frame(16'h0000, 1'b0, 1'b0);
    check("first bad holds R7", {31'd0, f_lk}, 32'd0);
    send_frame(16'h0000, 1'b0, 1'b0);
    check("second bad drops R7", {31'd0, f_lk}, 32'd1);
    check("los set on loss R4", {31'd0, los_o}, 32'd1);
    check("no word on loss R7", {31'd0, f_v}, 32'd0);

    // re-acquire at a shifted offset
    repeat (7) put_bit(1'b0);
    acquire("reacquire R7");

    // output enable
    oe_i = 1'b0;
    send_frame(16'h7E81, 1'b1, 1'b0);
    check("oe low gates enable R10", {31'd0, data_oe_o}, 32'd0);
    check("oe low zero data R10", {16'd0, f_d}, 32'd0);
    oe_i = 1'b1;
    #1;
    check("oe restored R10", {16'd0, data_o}, 32'h00007E81);

    // power-down
    @(negedge clk_i);
    pwrdn_i = 1'b1;
    @(posedge clk_i);
    #1;
    check("pwrdn lock_no R9", {31'd0, lock_no_o}, 32'd1);
    check("pwrdn los R9", {31'd0, los_o}, 32'd1);
    check("pwrdn oe R10", {31'd0, data_oe_o}, 32'd0);
    for (int k = 0; k < 5; k++) send_frame(SYNC, 1'b1, 1'b0);
    check("pwrdn ignores input R9", {31'd0, f_lk}, 32'd1);
    check("pwrdn no word R9", {31'd0, f_v}, 32'd0);
    @(negedge clk_i);
    pwrdn_i = 1'b0;
    acquire("after pwrdn R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule